// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block gathers 64 level-sensitive interrupt request lines and reports the most urgent active source to a processor. Each source has a programmable 8-bit priority byte. A non-zero byte enables the source, and its value sets the source's rank. A 64-bit mask holds off individual sources. A force word is also folded into the active set. Every clock the controller works out the winner. On the next edge it presents the winner's priority as the interrupt level and the winner's number offset by 64 as the vector.

Software reaches the block through a simple 32-bit register bus with a 256-byte window. Through it, software reads the live request lines, reads and writes the mask halves, reads and writes the priority bytes, reads the force word, and reads an acknowledge register that returns the current vector. An access the block does not support raises an error flag instead of data. This includes the per-level hardware acknowledge reads and any write outside the writable set.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the level output is 0 and the vector output is 24. All mask bits read as 1. All priority bytes and the force word read as 0.
- R2: The pending word follows the request inputs with no latching. A read at 0x00 returns sources 63..32 and a read at 0x04 returns sources 31..0. Writes to 0x00 or 0x04 raise no error and change nothing.
- R3: A write at 0x08 replaces mask bits 63..32 and a write at 0x0C replaces mask bits 31..0. Each write leaves the other half untouched, and both offsets read back. A source whose mask bit is 1 never wins.
- R4: The byte at offset 0x40+n is the priority byte of source n. A write there stores bits 7..0 of the write data, and a read returns the byte zero-extended. A value of zero disables the source.
- R5: Among sources that are requesting (or forced), enabled and unmasked, the one with the largest priority byte wins. The level output equals that byte.
- R6: When several active sources share the largest priority byte, the one with the highest index wins.
- R7: The vector output is the winner's index plus 64. With no active source, the vector is 24 and the level is 0.
- R8: A read at 0xE0 returns the vector currently shown on the vector output.
- R9: The force word reads at 0x10 (bits 63..32) and 0x14 (bits 31..0) and holds zero. A read of any offset outside the listed ones returns zero without an error.
- R10: A read at 0xE1 through 0xE7 raises the error flag for one cycle. So does a write to any offset other than 0x00, 0x04, 0x08, 0x0C and 0x40..0x7F. Such a write changes no state.
- R11: Level and vector are registered. They reflect the request lines and register contents sampled at the previous rising clock edge. Read data and the error flag appear on the edge that samples the access, and read data is 0 when there is no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Level-sensitive request lines, one per source |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Registered unsupported-access flag |
| cpu_level | output | 8 | Priority byte of the winning source, 0 if none |
| cpu_vector | output | 8 | Winner index plus 64, or 24 if none |

## Verification
On every cycle, the assertions check several properties. A zero level always pairs with the spurious vector 24, and the vector otherwise stays in the 64..127 range. A fully set mask forces the level to zero on the following edge. The error flag only follows a bus access, and read data stays zero after writes. The priority choice itself only shows in the bench's scenarios, which need a reference outcome computed per pattern. These cover the highest-byte-wins rule, the higher-index tie-break, the mask halves, the priority-byte enable and the readback values.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam logic [7:0] OFF_PEND_HI  = 8'h00;
  localparam logic [7:0] OFF_PEND_LO  = 8'h04;
  localparam logic [7:0] OFF_MASK_HI  = 8'h08;
  localparam logic [7:0] OFF_MASK_LO  = 8'h0C;
  localparam logic [7:0] OFF_FORCE_HI = 8'h10;
  localparam logic [7:0] OFF_FORCE_LO = 8'h14;
  localparam logic [7:0] OFF_PRIO     = 8'h40;
  localparam logic [7:0] OFF_SWACK    = 8'hE0;
  localparam logic [7:0] OFF_LVACK_LO = 8'hE1;
  localparam logic [7:0] OFF_LVACK_HI = 8'hE7;
endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs import prio_irq_pkg::*; #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 8,
  parameter int VEC_W   = 8,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           sel,
  input  logic                           wr,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [NUM_SRC-1:0]             pend,
  input  logic [VEC_W-1:0]               cur_vec,
  output logic [DATA_W-1:0]              rdata,
  output logic                           err,
  output logic [NUM_SRC-1:0]             mask,
  output logic [NUM_SRC-1:0]             force_w,
  output logic [NUM_SRC-1:0][PRIO_W-1:0] prio
);
  localparam int HALF  = NUM_SRC / 2;
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0]             mask_q;
  logic [NUM_SRC-1:0]             force_q;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;

  logic              in_prio;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] rel;
  logic              wr_ok;
  logic              rd_bad;
  logic [DATA_W-1:0] rd_val;

  assign rel     = addr - ADDR_W'(OFF_PRIO);
  assign in_prio = (addr >= ADDR_W'(OFF_PRIO)) &&
                   (addr <  ADDR_W'(OFF_PRIO) + ADDR_W'(NUM_SRC));
  assign idx     = rel[IDX_W-1:0];

  assign wr_ok = in_prio ||
                 addr == ADDR_W'(OFF_PEND_HI) || addr == ADDR_W'(OFF_PEND_LO) ||
                 addr == ADDR_W'(OFF_MASK_HI) || addr == ADDR_W'(OFF_MASK_LO);

  assign rd_bad = (addr >= ADDR_W'(OFF_LVACK_LO)) && (addr <= ADDR_W'(OFF_LVACK_HI));

  always_comb begin
    rd_val = '0;
    if (in_prio) begin
      rd_val = DATA_W'(prio_q[idx]);
    end else begin
      case (addr)
        ADDR_W'(OFF_PEND_HI):  rd_val = DATA_W'(pend[NUM_SRC-1:HALF]);
        ADDR_W'(OFF_PEND_LO):  rd_val = DATA_W'(pend[HALF-1:0]);
        ADDR_W'(OFF_MASK_HI):  rd_val = DATA_W'(mask_q[NUM_SRC-1:HALF]);
        ADDR_W'(OFF_MASK_LO):  rd_val = DATA_W'(mask_q[HALF-1:0]);
        ADDR_W'(OFF_FORCE_HI): rd_val = DATA_W'(force_q[NUM_SRC-1:HALF]);
        ADDR_W'(OFF_FORCE_LO): rd_val = DATA_W'(force_q[HALF-1:0]);
        ADDR_W'(OFF_SWACK):    rd_val = DATA_W'(cur_vec);
        default:               rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      force_q <= '0;
      prio_q  <= '0;
      rdata   <= '0;
      err     <= 1'b0;
    end else begin
      rdata <= (sel && !wr) ? rd_val : '0;
      err   <= sel && (wr ? !wr_ok : rd_bad);
      if (sel && wr) begin
        if (in_prio) begin
          prio_q[idx] <= wdata[PRIO_W-1:0];
        end else if (addr == ADDR_W'(OFF_MASK_HI)) begin
          mask_q[NUM_SRC-1:HALF] <= wdata[HALF-1:0];
        end else if (addr == ADDR_W'(OFF_MASK_LO)) begin
          mask_q[HALF-1:0] <= wdata[HALF-1:0];
        end
      end
    end
  end

  assign mask    = mask_q;
  assign force_w = force_q;
  assign prio    = prio_q;
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 8
) (
  input  logic [NUM_SRC-1:0]             active,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  output logic                           any,
  output logic [$clog2(NUM_SRC)-1:0]     win_idx,
  output logic [PRIO_W-1:0]              win_lvl
);
  localparam int IDX_W = $clog2(NUM_SRC);

  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (active[i] && prio[i] >= win_lvl) begin
        any     = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = prio[i];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_SRC  = 64,
  parameter int PRIO_W   = 8,
  parameter int VEC_W    = 8,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int VEC_BASE = 64,
  parameter int SPUR_VEC = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_err,
  output logic [PRIO_W-1:0]  cpu_level,
  output logic [VEC_W-1:0]   cpu_vector
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0]             mask_w;
  logic [NUM_SRC-1:0]             force_w;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_w;
  logic [NUM_SRC-1:0]             active;
  logic                           any;
  logic [IDX_W-1:0]               win_idx;
  logic [PRIO_W-1:0]              win_lvl;

  prio_irq_regs #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .pend(irq_in), .cur_vec(cpu_vector),
    .rdata(bus_rdata), .err(bus_err),
    .mask(mask_w), .force_w(force_w), .prio(prio_w)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_act
    assign active[g] = (irq_in[g] | force_w[g]) & (|prio_w[g]) & ~mask_w[g];
  end

  prio_irq_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .active(active), .prio(prio_w),
    .any(any), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_level  <= '0;
      cpu_vector <= VEC_W'(SPUR_VEC);
    end else begin
      cpu_level  <= any ? win_lvl : '0;
      cpu_vector <= any ? (VEC_W'(VEC_BASE) + VEC_W'(win_idx)) : VEC_W'(SPUR_VEC);
    end
  end
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 8,
  parameter int VEC_W   = 8,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               bus_err,
  input logic [PRIO_W-1:0]  cpu_level,
  input logic [VEC_W-1:0]   cpu_vector,
  input logic [NUM_SRC-1:0] mask
);
  // R1: first cycle after reset shows nothing pending
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cpu_level == '0 && cpu_vector == VEC_W'(24)));

  // R7: zero level and spurious vector go together
  a_r7_spurious_pair: assert property (@(posedge clk) disable iff (rst)
    (cpu_level == '0) == (cpu_vector == VEC_W'(24)));

  // R7: a real vector lies in the source range
  a_r7_vector_range: assert property (@(posedge clk) disable iff (rst)
    cpu_vector == VEC_W'(24) ||
    (cpu_vector >= VEC_W'(64) && cpu_vector < VEC_W'(64 + NUM_SRC)));

  // R3: everything masked means no level on the next edge
  a_r3_all_masked: assert property (@(posedge clk) disable iff (rst)
    $past(&mask) |-> cpu_level == '0);

  // R10: the error flag only follows an access
  a_r10_err_needs_access: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_sel));

  // R11: a write or idle cycle returns no read data
  a_r11_rdata_idle: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_sel && !bus_wr) |-> bus_rdata == '0);
endmodule

bind prio_irq_ctrl prio_irq_chk #(
  .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .bus_err(bus_err),
  .cpu_level(cpu_level), .cpu_vector(cpu_vector), .mask(mask_w)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_in = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [7:0]  cpu_level;
  logic [7:0]  cpu_vector;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [63:0] m_mask;
  logic [7:0]  m_prio [64];

  always #2 clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err),
    .cpu_level(cpu_level), .cpu_vector(cpu_vector)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, output logic e);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
    e = bus_err;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 0;
    d = bus_rdata; e = bus_err;
  endtask

  // Expected level/vector from the requirement text: highest byte wins, ties to higher index
  task automatic expect_out(output logic [7:0] lvl, output logic [7:0] vec);
    int best = -1;
    lvl = 0;
    for (int i = 0; i < 64; i++) begin
      if (irq_in[i] && !m_mask[i] && m_prio[i] != 0 && m_prio[i] >= lvl) begin
        best = i; lvl = m_prio[i];
      end
    end
    vec = (best < 0) ? 8'd24 : 8'(64 + best);
  endtask

  task automatic check_out(input string req);
    logic [7:0] el, ev;
    @(posedge clk); #1;
    expect_out(el, ev);
    chk(cpu_level == el, {req, " level"}, 64'(cpu_level), 64'(el));
    chk(cpu_vector == ev, {req, " vector"}, 64'(cpu_vector), 64'(ev));
  endtask

  task automatic set_prio(input int n, input logic [31:0] d);
    logic e;
    bus_write(8'(8'h40 + n), d, e);
    m_prio[n] = d[7:0];
  endtask

  task automatic set_mask(input logic [63:0] m);
    logic e;
    bus_write(8'h08, m[63:32], e);
    bus_write(8'h0C, m[31:0], e);
    m_mask = m;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e;
    logic [63:0] lf;
    m_mask = '1;
    for (int i = 0; i < 64; i++) m_prio[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;

    // R1 reset state
    chk(cpu_level == 0, "R1 level", 64'(cpu_level), 0);
    chk(cpu_vector == 24, "R1 vector", 64'(cpu_vector), 24);
    bus_read(8'h08, d, e); chk(d == 32'hFFFF_FFFF, "R1 mask hi", 64'(d), 64'hFFFF_FFFF);
    bus_read(8'h0C, d, e); chk(d == 32'hFFFF_FFFF, "R1 mask lo", 64'(d), 64'hFFFF_FFFF);
    for (int i = 0; i < 64; i++) begin
      bus_read(8'(8'h40 + i), d, e); chk(d == 0, "R1 prio byte", 64'(d), 0);
    end
    // R9 force word and unlisted reads
    bus_read(8'h10, d, e); chk(d == 0 && !e, "R9 force hi", 64'(d), 0);
    bus_read(8'h14, d, e); chk(d == 0 && !e, "R9 force lo", 64'(d), 0);
    bus_read(8'h20, d, e); chk(d == 0 && !e, "R9 unlisted 0x20", 64'(d), 0);
    bus_read(8'hF0, d, e); chk(d == 0 && !e, "R9 unlisted 0xF0", 64'(d), 0);

    // R3 masked sources: enabled and requesting but all masked
    set_prio(5, 32'd9);
    irq_in = 64'h20;
    check_out("R3 all masked");

    // R4/R7 single-source sweep, with pending readback R2
    set_mask(64'h0);
    for (int i = 0; i < 64; i++) set_prio(i, 32'(i + 1));
    for (int i = 0; i < 64; i++) begin
      irq_in = 64'd1 << i;
      check_out("R7 single source");
      bus_read(8'h00, d, e); chk(d == irq_in[63:32], "R2 pending hi", 64'(d), 64'(irq_in[63:32]));
      bus_read(8'h04, d, e); chk(d == irq_in[31:0], "R2 pending lo", 64'(d), 64'(irq_in[31:0]));
    end
    // R8 software acknowledge matches vector output
    irq_in = 64'h0000_0400_0000_0000;
    check_out("R8 setup");
    bus_read(8'hE0, d, e); chk(d == 32'(cpu_vector) && d == 32'd106, "R8 swack", 64'(d), 106);
    // R2 pending writes ignored
    bus_write(8'h04, 32'hFFFF_FFFF, e); chk(!e, "R2 write no err", 64'(e), 0);
    bus_write(8'h00, 32'hFFFF_FFFF, e); chk(!e, "R2 write no err", 64'(e), 0);
    bus_read(8'h04, d, e); chk(d == 0, "R2 pending unchanged", 64'(d), 0);
    check_out("R2 output unchanged");

    // R6 ties: all bytes equal, everything requesting
    for (int i = 0; i < 64; i++) set_prio(i, 32'd5);
    irq_in = '1;
    check_out("R6 tie all");
    irq_in = 64'h0000_0001_8000_0001;
    check_out("R6 tie three");

    // R4 zero byte disables, only low byte stored
    set_prio(32, 32'h1234_5600);
    bus_read(8'h60, d, e); chk(d == 0, "R4 low byte only", 64'(d), 0);
    check_out("R4 disabled source");
    set_prio(0, 32'hABCD_EF07);
    bus_read(8'h40, d, e); chk(d == 32'h07, "R4 readback", 64'(d), 7);
    check_out("R5 high byte wins");

    // R3 mask halves independent
    set_mask(64'hFFFF_FFFF_0000_0000);
    bus_write(8'h0C, 32'h0000_0001, e);
    m_mask[31:0] = 32'h1;
    bus_read(8'h08, d, e); chk(d == 32'hFFFF_FFFF, "R3 hi kept", 64'(d), 64'hFFFF_FFFF);
    bus_read(8'h0C, d, e); chk(d == 32'h1, "R3 lo write", 64'(d), 1);
    check_out("R3 masked half");

    // R10 error cases
    for (int a = 8'hE1; a <= 8'hE7; a++) begin
      bus_read(8'(a), d, e); chk(e, "R10 level ack read", 64'(e), 1);
    end
    bus_read(8'hE0, d, e); chk(!e, "R10 swack no err", 64'(e), 0);
    bus_write(8'h10, 32'hFFFF_FFFF, e); chk(e, "R10 force write err", 64'(e), 1);
    bus_read(8'h10, d, e); chk(d == 0, "R10 force untouched", 64'(d), 0);
    bus_write(8'hE0, 32'h1, e); chk(e, "R10 swack write err", 64'(e), 1);
    bus_write(8'h80, 32'h1, e); chk(e, "R10 0x80 write err", 64'(e), 1);
    bus_write(8'h09, 32'h0, e); chk(e, "R10 0x09 write err", 64'(e), 1);
    bus_read(8'h08, d, e); chk(d == 32'hFFFF_FFFF, "R10 mask untouched", 64'(d), 64'hFFFF_FFFF);
    @(negedge clk);
    chk(bus_err == 0, "R10 err one cycle", 64'(bus_err), 0);

    // R5/R6 sweep: small byte range for frequent ties and zeros
    lf = 64'h9E37_79B9_7F4A_7C15;
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 64; i++) set_prio(i, 32'((i * 29 + k * 13) % 6));
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 7); lf = lf ^ (lf << 17);
      set_mask(lf & {lf[31:0], lf[63:32]});
      for (int p = 0; p < 60; p++) begin
        lf = lf ^ (lf << 13); lf = lf ^ (lf >> 7); lf = lf ^ (lf << 17);
        irq_in = (p % 3 == 0) ? lf : (lf & (lf >> 5));
        check_out("R5 sweep");
      end
    end

    // R11 latency: a change shows only after the next edge
    set_mask(64'h0);
    for (int i = 0; i < 64; i++) set_prio(i, 32'd1);
    irq_in = 64'h8;
    check_out("R11 setup");
    @(negedge clk);
    irq_in = 64'h10;
    #1;
    chk(cpu_vector == 8'd67, "R11 holds before edge", 64'(cpu_vector), 67);
    check_out("R11 after edge");
    irq_in = '0;
    check_out("R7 none active");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule